// File: doc/BRIEF.md
# Shadowed-Duty PWM Timer

An 8-bit up-counter drives a single pulse-width output. The counter climbs by one on each cycle where the clock-enable input is high. When it reaches a programmable ceiling it returns to zero. Prescaling is handled outside the block, which only sees the enable pulses.

The duty value is double-buffered. Software writes it into a holding register, and the comparator takes it over only in the cycle when the counter returns to zero. A period that is already running therefore never sees a half-applied value. Reading the duty address returns the holding register, so software always gets back the value it wrote last.

A duty of zero, or a duty at or above the ceiling, gives a level that stays constant for the whole period. Two mode bits choose:
- normal polarity,
- inverted polarity,
- a disconnected pin, which drives low.

A wrap flag and a compare-match flag each feed an interrupt request. The request is gated by a local enable and by a global enable input.

Top module: `pwm_timer8`

## Requirements
- R1: After reset, the ceiling reads 0xFF. The control register, the duty holding value, the flags, the counter and the pin all read or drive zero.
- R2: On a cycle with tick_en high, the counter advances by one. When the counter is at or above the ceiling, it returns to 0x00 instead. With tick_en low, the counter holds.
- R3: A duty write (address 2) lands in the holding register. The comparator copies it only in a tick cycle where the counter wraps, and the value copied is the one held before that edge.
- R4: A read of address 2 returns the most recently written duty value, whether or not it has been copied yet.
- R5: With control bits [1:0] = 2'b10, the pin is high while the counter is below the active duty and low otherwise, for 0 < duty < ceiling.
- R6: With control bits [1:0] = 2'b11, the pin is the inverse of the R5 level.
- R7: With control bit 1 clear (modes 2'b00 and 2'b01), the pin drives low.
- R8: An active duty of 0x00 gives a steady low pin in mode 2'b10 and a steady high pin in mode 2'b11. A duty at or above the ceiling gives a steady high pin in mode 2'b10 and a steady low pin in mode 2'b11. A zero duty takes precedence over the ceiling rule.
- R9: Flag bit 0 (wrap) is set by every wrap. Flag bit 1 (match) is set by every tick cycle where the counter equals the active duty.
- R10: Writing address 3 clears each flag whose data bit is 1. Bits written as 0 leave their flag unchanged. A set event in the same cycle as a clear wins.
- R11: ovf_irq is high only when flag bit 0, control bit 2 and glob_irq_en are all high. cmp_irq is high only when flag bit 1, control bit 3 and glob_irq_en are all high.
- R12: The register map is: address 0 is control, 1 is the ceiling, 2 is the duty, 3 is the flags. A ceiling write takes effect on the next cycle. If the counter is above the new ceiling, it wraps at its next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable (external prescaler pulse) |
| glob_irq_en | input | 1 | Global interrupt enable |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pwm_out | output | 1 | PWM pin |
| ovf_irq | output | 1 | Wrap interrupt request |
| cmp_irq | output | 1 | Compare-match interrupt request |

## Verification
The hardest case to reach from the ports is a duty write that lands in the same cycle as a wrap. The old holding value must still be the one copied to the comparator. The bench reaches it by writing duty values while ticks run continuously, so some writes fall on the wrap edge. It also lowers the ceiling below the running count, which forces an early wrap. The steady-level cases are checked by counting pin transitions over a full period after the zero or ceiling duty has been latched.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_TOP  = 2'd1,
    RA_DUTY = 2'd2,
    RA_FLAG = 2'd3
  } reg_addr_e;

  localparam int CTL_W      = 4;
  localparam int CTL_OVF_IE = 2;
  localparam int CTL_CMP_IE = 3;
  localparam int NUM_FLAGS  = 2;
  localparam int FLG_OVF    = 0;
  localparam int FLG_CMP    = 1;

  // Polarity stage: mode 2'b10 passes, 2'b11 inverts, others park low.
  function automatic logic drive_pin(input logic [1:0] mode, input logic raw);
    logic pin;
    unique case (mode)
      2'b10:   pin = raw;
      2'b11:   pin = ~raw;
      default: pin = 1'b0;
    endcase
    return pin;
  endfunction
endpackage

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         wrap_evt
);
  // Wrap on reaching or passing the ceiling, so a lowered ceiling still wraps.
  assign wrap_evt = tick_en && (cnt >= top);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (tick_en) begin
      cnt <= wrap_evt ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         wr_duty,
  input  logic [W-1:0] wdata,
  input  logic         wrap_evt,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] top,
  output logic [W-1:0] hold_q,
  output logic [W-1:0] active_q,
  output logic         match_evt,
  output logic         raw_lvl
);
  // Normal-polarity level: zero duty low, duty at/above ceiling high, else cnt < duty.
  function automatic logic duty_level(input logic [W-1:0] c,
                                      input logic [W-1:0] d,
                                      input logic [W-1:0] t);
    logic lvl;
    if (d == '0)      lvl = 1'b0;
    else if (d >= t)  lvl = 1'b1;
    else              lvl = (c < d);
    return lvl;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (wr_duty) begin
      hold_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= '0;
    end else if (wrap_evt) begin
      active_q <= hold_q;
    end
  end

  assign match_evt = tick_en && (cnt == active_q);
  assign raw_lvl   = duty_level(cnt, active_q, top);
endmodule

// File: rtl/pwm_flag_bank.sv
module pwm_flag_bank #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flags[i] <= 1'b0;
      end else if (set_evt[i]) begin
        flags[i] <= 1'b1;
      end else if (clr_mask[i]) begin
        flags[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
  import pwm_tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         glob_irq_en,
  input  logic         bus_we,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic         pwm_out,
  output logic         ovf_irq,
  output logic         cmp_irq
);
  localparam int CPAD = W - CTL_W;
  localparam int FPAD = W - NUM_FLAGS;

  logic [CTL_W-1:0]     ctrl_q;
  logic [W-1:0]         top_q;
  logic [W-1:0]         cnt_q;
  logic [W-1:0]         hold_q;
  logic [W-1:0]         active_q;
  logic                 wrap_evt;
  logic                 match_evt;
  logic                 raw_lvl;
  logic [NUM_FLAGS-1:0] flags_q;
  logic [NUM_FLAGS-1:0] set_evt;
  logic [NUM_FLAGS-1:0] clr_mask;
  logic                 wr_ctrl, wr_top, wr_duty, wr_flag;
  reg_addr_e            addr;

  assign addr    = reg_addr_e'(bus_addr);
  assign wr_ctrl = bus_we && (addr == RA_CTRL);
  assign wr_top  = bus_we && (addr == RA_TOP);
  assign wr_duty = bus_we && (addr == RA_DUTY);
  assign wr_flag = bus_we && (addr == RA_FLAG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= bus_wdata[CTL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_q <= '1;
    end else if (wr_top) begin
      top_q <= bus_wdata;
    end
  end

  pwm_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .top      (top_q),
    .cnt      (cnt_q),
    .wrap_evt (wrap_evt)
  );

  pwm_compare #(.W(W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .wr_duty   (wr_duty),
    .wdata     (bus_wdata),
    .wrap_evt  (wrap_evt),
    .cnt       (cnt_q),
    .top       (top_q),
    .hold_q    (hold_q),
    .active_q  (active_q),
    .match_evt (match_evt),
    .raw_lvl   (raw_lvl)
  );

  assign set_evt[FLG_OVF]  = wrap_evt;
  assign set_evt[FLG_CMP]  = match_evt;
  assign clr_mask          = wr_flag ? bus_wdata[NUM_FLAGS-1:0] : '0;

  pwm_flag_bank #(.N(NUM_FLAGS)) u_flg (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_evt  (set_evt),
    .clr_mask (clr_mask),
    .flags    (flags_q)
  );

  assign pwm_out = drive_pin(ctrl_q[1:0], raw_lvl);
  assign ovf_irq = flags_q[FLG_OVF] && ctrl_q[CTL_OVF_IE] && glob_irq_en;
  assign cmp_irq = flags_q[FLG_CMP] && ctrl_q[CTL_CMP_IE] && glob_irq_en;

  always_comb begin
    unique case (addr)
      RA_CTRL: bus_rdata = {{CPAD{1'b0}}, ctrl_q};
      RA_TOP:  bus_rdata = top_q;
      RA_DUTY: bus_rdata = hold_q;
      RA_FLAG: bus_rdata = {{FPAD{1'b0}}, flags_q};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pwm_timer8_chk.sv
module pwm_timer8_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_en,
  input logic         glob_irq_en,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] hold_q,
  input logic [W-1:0] active_q,
  input logic         wrap_evt,
  input logic [3:0]   ctrl_q,
  input logic [1:0]   flags_q,
  input logic         pwm_out,
  input logic         ovf_irq,
  input logic         cmp_irq
);
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_q));

  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (cnt_q == '0));

  p_active_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_evt |=> $stable(active_q));

  p_active_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (active_q == $past(hold_q)));

  p_pin_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[1] |-> !pwm_out);

  p_zero_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[1:0] == 2'b10 && active_q == '0) |-> !pwm_out);

  p_ovf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> flags_q[0]);

  p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_irq || cmp_irq) |-> glob_irq_en);
endmodule

bind pwm_timer8 pwm_timer8_chk #(.W(W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_en     (tick_en),
  .glob_irq_en (glob_irq_en),
  .cnt_q       (cnt_q),
  .hold_q      (hold_q),
  .active_q    (active_q),
  .wrap_evt    (wrap_evt),
  .ctrl_q      (ctrl_q),
  .flags_q     (flags_q),
  .pwm_out     (pwm_out),
  .ovf_irq     (ovf_irq),
  .cmp_irq     (cmp_irq)
);

// File: tb/pwm_timer8_tb_top.sv
`timescale 1ns/1ps
module pwm_timer8_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       glob_irq_en = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       pwm_out, ovf_irq, cmp_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int m_cnt, m_top, m_hold, m_act, m_ctrl, m_ovf, m_cmp;

  always #5 clk = ~clk;

  pwm_timer8 dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .glob_irq_en(glob_irq_en),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pwm_out(pwm_out), .ovf_irq(ovf_irq), .cmp_irq(cmp_irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int m_pin();
    int lvl;
    if (m_act == 0)           lvl = 0;
    else if (m_act >= m_top)  lvl = 1;
    else                      lvl = (m_cnt < m_act) ? 1 : 0;
    case (m_ctrl & 3)
      2: return lvl;
      3: return 1 - lvl;
      default: return 0;
    endcase
  endfunction

  function automatic void m_step(input int we, input int a, input int d, input int ten);
    bit wrap, match;
    int clr;
    wrap  = (ten != 0) && (m_cnt >= m_top);
    match = (ten != 0) && (m_cnt == m_act);
    clr   = (we != 0 && a == 3) ? d : 0;
    m_ovf = wrap  ? 1 : (((clr & 1) != 0) ? 0 : m_ovf);
    m_cmp = match ? 1 : (((clr & 2) != 0) ? 0 : m_cmp);
    if (ten != 0) m_cnt = wrap ? 0 : m_cnt + 1;
    if (wrap) m_act = m_hold;
    if (we != 0 && a == 2) m_hold = d;
    if (we != 0 && a == 1) m_top = d;
    if (we != 0 && a == 0) m_ctrl = d & 15;
  endfunction

  // One clock: drive, edge, update model, compare away from the edge.
  task automatic cyc(input int we, input int a, input int d, input int ten);
    bus_we = (we != 0); bus_addr = 2'(a); bus_wdata = 8'(d); tick_en = (ten != 0);
    @(posedge clk);
    m_step(we, a, d, ten);
    #2;
    chk("R5/R6/R7/R8 pin", int'(pwm_out), m_pin());
    chk("R11 ovf_irq", int'(ovf_irq),
        (m_ovf != 0 && (m_ctrl & 4) != 0 && glob_irq_en) ? 1 : 0);
    chk("R11 cmp_irq", int'(cmp_irq),
        (m_cmp != 0 && (m_ctrl & 8) != 0 && glob_irq_en) ? 1 : 0);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    bus_we = 1'b0; bus_addr = 2'(a);
    #1;
    chk(tag, int'(bus_rdata), exp);
  endtask

  task automatic run(input int n, input int ten);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, ten);
  endtask

  task automatic steady(input int n, input int lvl, input string tag);
    int flips = 0;
    logic prev;
    prev = pwm_out;
    for (int i = 0; i < n; i++) begin
      cyc(0, 0, 0, 1);
      if (pwm_out != prev) flips++;
      prev = pwm_out;
    end
    chk({tag, " flips"}, flips, 0);
    chk({tag, " level"}, int'(pwm_out), lvl);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    m_cnt = 0; m_top = 255; m_hold = 0; m_act = 0; m_ctrl = 0; m_ovf = 0; m_cmp = 0;

    // R1 reset state
    rd(1, 255, "R1 top reset");
    rd(0, 0, "R1 ctrl reset");
    rd(2, 0, "R1 duty reset");
    rd(3, 0, "R1 flags reset");
    chk("R1 pin reset", int'(pwm_out), 0);

    // R12 map, R5 normal mode; R3 shadowing, R4 readback
    cyc(1, 0, 8'h02, 0);
    cyc(1, 1, 9, 0);
    rd(1, 9, "R12 top write");
    cyc(1, 2, 4, 0);
    rd(2, 4, "R4 pending duty read");
    cyc(0, 0, 0, 1);
    chk("R3 old duty still active", int'(pwm_out), 0);
    run(25, 1);
    cyc(1, 2, 7, 1);
    rd(2, 7, "R4 duty read before latch");
    // R2 gapped ticks
    for (int i = 0; i < 30; i++) cyc(0, 0, 0, i % 2);
    // R3 writes landing on assorted cycles including wrap edges
    for (int i = 0; i < 12; i++) begin
      cyc(1, 2, 2 + (i % 6), 1);
      run(i % 4, 1);
    end

    // R6 inverted
    cyc(1, 0, 8'h03, 1);
    cyc(1, 2, 5, 1);
    run(25, 1);

    // R8 steady levels
    cyc(1, 0, 8'h02, 1); cyc(1, 2, 0, 1); run(12, 1);
    steady(20, 0, "R8 zero duty normal");
    cyc(1, 0, 8'h03, 1);
    steady(20, 1, "R8 zero duty inverted");
    cyc(1, 2, 9, 1); run(12, 1);
    steady(20, 0, "R8 ceiling duty inverted");
    cyc(1, 0, 8'h02, 1);
    steady(20, 1, "R8 ceiling duty normal");

    // R7 disconnected modes
    cyc(1, 2, 4, 1); run(12, 1);
    cyc(1, 0, 8'h00, 1); run(12, 1);
    chk("R7 mode 00 low", int'(pwm_out), 0);
    cyc(1, 0, 8'h01, 1); run(12, 1);
    chk("R7 mode 01 low", int'(pwm_out), 0);

    // R12 lower ceiling below the running count
    cyc(1, 0, 8'h02, 1);
    cyc(1, 1, 40, 1); run(30, 1);
    cyc(1, 1, 3, 1); run(20, 1);

    // R9, R10, R11 flags and interrupts
    glob_irq_en = 1'b0;
    cyc(1, 0, 8'h0E, 1); cyc(1, 2, 2, 1); run(12, 1);
    rd(3, 3, "R9 both flags set");
    chk("R11 no irq without global", int'(ovf_irq | cmp_irq), 0);
    glob_irq_en = 1'b1;
    cyc(0, 0, 0, 0);
    chk("R11 ovf_irq with global", int'(ovf_irq), 1);
    chk("R11 cmp_irq with global", int'(cmp_irq), 1);
    cyc(1, 3, 8'h01, 0);
    rd(3, 2, "R10 clear wrap flag only");
    cyc(1, 3, 8'h00, 0);
    rd(3, 2, "R10 zero write no effect");
    cyc(1, 3, 8'h02, 0);
    rd(3, 0, "R10 clear match flag");
    cyc(1, 0, 8'h06, 0); run(10, 1);
    chk("R11 cmp_irq masked locally", int'(cmp_irq), 0);
    run(20, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule